// File: doc/BRIEF.md
# Serial Transmitter with Line Break

This block is the transmit half of a byte-oriented asynchronous serial port. Bytes written through a simple write strobe are held in a small queue. A shift engine turns each byte into a frame on a single output line. The frame shape comes from a 7-bit line-control word: word length, parity mode, stop-bit count and a break request. Bit timing comes from a divider: a 16x sub-tick every `divisor` clocks and one bit boundary every sixteenth sub-tick.

The break request pulls the line low at once. If a character is being shifted at that moment, it is dropped and never finished. Once a break has started, the line stays low for at least one full frame plus one bit, even if the request goes away on the next cycle. Bytes written while a break is active wait in the queue and go out after the break ends. Two status outputs tell the host whether the queue has room for more data (queue empty) and whether everything has left the wire (queue empty and shifter idle).

Top module: `uart_tx_brk`

## Requirements
- R1: After reset, `txd` is high and both `thr_empty` and `tx_empty` are 1.
- R2: One bit lasts exactly 16 × `divisor` clock cycles, and frames start on a bit boundary.
- R3: A frame is sent as follows, and the line is high between frames:
  - one low start bit;
  - the data bits, least significant first; `line_ctl[1:0]` = 0,1,2,3 selects 5,6,7,8 data bits;
  - the parity bit, if enabled;
  - the stop bits, high; `line_ctl[2]`=1 gives two stop bits, otherwise one.
- R4: Parity is controlled as follows:
  - `line_ctl[3]` enables the parity bit;
  - with `line_ctl[5]`=0, `line_ctl[4]`=1 gives even parity and 0 gives odd parity, both over the sent data bits;
  - with `line_ctl[5]`=1 (stick), the parity bit is the inverse of `line_ctl[4]`.
- R5: `thr_empty` is 1 exactly when no byte waits in the queue. `tx_empty` is 1 only when, in addition, no frame is being shifted.
- R6: The queue holds 16 bytes and sends them in write order, back to back. A write while the queue is full is dropped.
- R7: Setting `line_ctl[6]` (break) drives `txd` low from the next cycle on.
- R8: A break raised during a frame abandons that character. It is never completed or resent, and the next queued byte follows the break.
- R9: The break holds `txd` low for at least (N+1) and at most (N+2) bit times, where N is the frame length for the current settings. It is released on a bit boundary once the request is clear.
- R10: Bytes written during a break stay queued (`thr_empty`=0) and are sent after the break ends.
- R11: With `divisor` = 0 no bit boundaries occur: `txd` stays high and queued bytes are kept until a nonzero divisor is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| divisor | input | 16 | Baud divisor; bit time is 16 × divisor clocks, 0 stops the clock |
| line_ctl | input | 7 | [1:0] word length, [2] two stop bits, [3] parity on, [4] even select, [5] stick parity, [6] break |
| wr_en | input | 1 | Write strobe for one byte |
| wr_data | input | 8 | Byte to queue |
| txd | output | 1 | Serial line, idle high |
| thr_empty | output | 1 | Queue holds no byte |
| tx_empty | output | 1 | Queue empty and shifter idle |

## Verification
Random frames use all word lengths, parity modes, stop counts and small divisors. A bench model decodes each frame at mid-bit, so any misplaced parity, stop or data bit shows up as a mismatch. A 0x01 byte at a large divisor isolates the start-bit length, which separates correct bit timing from off-by-one divider errors. Two break cases are run. In the first, the break is pulsed for one cycle in mid-character; the low run must fall inside the (N+1)…(N+2) bit window and the next decoded byte must be the one after the dropped character. In the second, a long break is held while idle and a byte is queued during it. A full-queue burst written with a zero divisor checks ordering, the dropped 17th write and the zero-divisor hold.

// File: rtl/utx_pkg.sv
package utx_pkg;

    localparam int FRAME_W = 12;
    localparam int LEN_W   = 4;

    typedef struct packed {
        logic       brk;
        logic       par_stick;
        logic       par_even;
        logic       par_en;
        logic       stop2;
        logic [1:0] wlen;
    } line_ctl_t;

    typedef enum logic [1:0] {
        TX_IDLE  = 2'd0,
        TX_SHIFT = 2'd1,
        TX_BREAK = 2'd2
    } tx_state_e;

    typedef struct packed {
        logic [FRAME_W-1:0] bits;
        logic [LEN_W-1:0]   nbits;
    } frame_t;

    function automatic logic [LEN_W-1:0] data_len(line_ctl_t c);
        return LEN_W'(5) + LEN_W'(c.wlen);
    endfunction

    function automatic logic [LEN_W-1:0] frame_len(line_ctl_t c);
        return LEN_W'(1) + data_len(c) + LEN_W'(c.par_en) + (c.stop2 ? LEN_W'(2) : LEN_W'(1));
    endfunction

    function automatic frame_t build_frame(logic [7:0] d, line_ctl_t c);
        frame_t           f;
        logic [LEN_W-1:0] nd;
        logic [7:0]       dm;
        logic             par;
        nd = data_len(c);
        dm = '0;
        f.bits = '1;
        f.bits[0] = 1'b0;
        for (int i = 0; i < 8; i++) begin
            if (i < int'(nd)) begin
                dm[i] = d[i];
                f.bits[i+1] = d[i];
            end
        end
        if (c.par_stick) par = ~c.par_even;
        else if (c.par_even) par = ^dm;
        else par = ~^dm;
        if (c.par_en) f.bits[nd + LEN_W'(1)] = par;
        f.nbits = frame_len(c);
        return f;
    endfunction

endpackage

// File: rtl/utx_baud.sv
module utx_baud #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] divisor,
    output logic             bit_tick
);
    localparam int SUB_W = 4;

    logic [DIV_W-1:0] pre_cnt;
    logic [SUB_W-1:0] sub_cnt;
    logic             sub_tick;

    assign sub_tick = (divisor != '0) && (pre_cnt >= divisor - DIV_W'(1));
    assign bit_tick = sub_tick && (sub_cnt == '1);

    always_ff @(posedge clk) begin
        if (rst || divisor == '0) begin
            pre_cnt <= '0;
            sub_cnt <= '0;
        end else if (sub_tick) begin
            pre_cnt <= '0;
            sub_cnt <= sub_cnt + SUB_W'(1);
        end else begin
            pre_cnt <= pre_cnt + DIV_W'(1);
        end
    end

    assert_no_tick_zero_div_R11: assert property (@(posedge clk) disable iff (rst)
        (divisor == '0) |-> !bit_tick);

    assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (rst)
        bit_tick |=> !bit_tick);

endmodule

// File: rtl/utx_fifo.sv
module utx_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             empty
);
    localparam int AW = $clog2(DEPTH);
    localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic [AW:0]      count;
    logic             full, do_push, do_pop;

    assign full    = (count == FULL_CNT);
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + AW'(1);
            if (do_pop)  rd_ptr <= rd_ptr + AW'(1);
            case ({do_push, do_pop})
                2'b10:   count <= count + (AW+1)'(1);
                2'b01:   count <= count - (AW+1)'(1);
                default: count <= count;
            endcase
        end
    end

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
        count <= FULL_CNT);

    assert_no_underflow_R6: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);

    assert_full_drop_R6: assert property (@(posedge clk) disable iff (rst)
        (full && push && !pop) |=> (count == FULL_CNT));

endmodule

// File: rtl/utx_shift.sv
module utx_shift
    import utx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      bit_tick,
    input  line_ctl_t ctl,
    input  logic      fifo_empty,
    input  logic [7:0] fifo_data,
    output logic      fifo_pop,
    output logic      txd,
    output logic      idle
);
    tx_state_e          state;
    logic [FRAME_W-1:0] shreg;
    logic [LEN_W-1:0]   left;
    logic [LEN_W-1:0]   hold;
    logic               brk_entry;
    logic               launch;
    frame_t             nf;

    assign nf        = build_frame(fifo_data, ctl);
    assign brk_entry = ctl.brk && (state != TX_BREAK);
    assign launch    = !brk_entry && bit_tick && !fifo_empty &&
                       ((state == TX_IDLE) || (state == TX_SHIFT && left == '0));
    assign fifo_pop  = launch;
    assign idle      = (state == TX_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= TX_IDLE;
            txd   <= 1'b1;
            shreg <= '1;
            left  <= '0;
            hold  <= '0;
        end else if (brk_entry) begin
            state <= TX_BREAK;
            txd   <= 1'b0;
            hold  <= frame_len(ctl) + LEN_W'(2);
        end else if (launch) begin
            state <= TX_SHIFT;
            txd   <= nf.bits[0];
            shreg <= {1'b1, nf.bits[FRAME_W-1:1]};
            left  <= nf.nbits - LEN_W'(1);
        end else if (bit_tick) begin
            case (state)
                TX_SHIFT: begin
                    if (left != '0) begin
                        txd   <= shreg[0];
                        shreg <= {1'b1, shreg[FRAME_W-1:1]};
                        left  <= left - LEN_W'(1);
                    end else begin
                        state <= TX_IDLE;
                        txd   <= 1'b1;
                    end
                end
                TX_BREAK: begin
                    if (hold > LEN_W'(1)) begin
                        hold <= hold - LEN_W'(1);
                    end else if (!ctl.brk) begin
                        state <= TX_IDLE;
                        txd   <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    assert_break_drives_low_R7: assert property (@(posedge clk) disable iff (rst)
        ctl.brk |=> !txd);

    assert_hold_keeps_low_R9: assert property (@(posedge clk) disable iff (rst)
        (state == TX_BREAK && hold > LEN_W'(1)) |=> !txd);

    assert_idle_line_high_R3: assert property (@(posedge clk) disable iff (rst)
        (state == TX_IDLE) |-> txd);

    assert_no_pop_in_break_R10: assert property (@(posedge clk) disable iff (rst)
        (state == TX_BREAK) |-> !fifo_pop);

endmodule

// File: rtl/uart_tx_brk.sv
module uart_tx_brk
    import utx_pkg::*;
#(
    parameter int DIV_W  = 16,
    parameter int QDEPTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] divisor,
    input  logic [6:0]       line_ctl,
    input  logic             wr_en,
    input  logic [7:0]       wr_data,
    output logic             txd,
    output logic             thr_empty,
    output logic             tx_empty
);
    line_ctl_t  ctl;
    logic       bit_tick;
    logic       pop;
    logic [7:0] head;
    logic       q_empty;
    logic       sh_idle;

    assign ctl = line_ctl_t'(line_ctl);

    utx_baud #(.DIV_W(DIV_W)) u_baud (
        .clk      (clk),
        .rst      (rst),
        .divisor  (divisor),
        .bit_tick (bit_tick)
    );

    utx_fifo #(.WIDTH(8), .DEPTH(QDEPTH)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .push      (wr_en),
        .push_data (wr_data),
        .pop       (pop),
        .head      (head),
        .empty     (q_empty)
    );

    utx_shift u_shift (
        .clk        (clk),
        .rst        (rst),
        .bit_tick   (bit_tick),
        .ctl        (ctl),
        .fifo_empty (q_empty),
        .fifo_data  (head),
        .fifo_pop   (pop),
        .txd        (txd),
        .idle       (sh_idle)
    );

    assign thr_empty = q_empty;
    assign tx_empty  = q_empty && sh_idle;

    assert_status_order_R5: assert property (@(posedge clk) disable iff (rst)
        (tx_empty && !wr_en) |=> thr_empty);

endmodule

// File: tb/uart_tx_brk_bench.sv
`timescale 1ns/1ps
module uart_tx_brk_bench;
    logic        clk = 0;
    logic        rst = 1;
    logic [15:0] divisor = 16'd1;
    logic [6:0]  line_ctl = 7'h03;
    logic        wr_en = 0;
    logic [7:0]  wr_data = 0;
    logic        txd, thr_empty, tx_empty;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    uart_tx_brk u_uart_tx_brk (
        .clk(clk), .rst(rst), .divisor(divisor), .line_ctl(line_ctl),
        .wr_en(wr_en), .wr_data(wr_data), .txd(txd),
        .thr_empty(thr_empty), .tx_empty(tx_empty)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int exp_frame(input logic [7:0] d, input logic [6:0] c, output logic [11:0] b);
        int nd, n, ones;
        logic p;
        nd = 5 + int'(c[1:0]);
        b = 12'hFFF;
        b[0] = 0;
        ones = 0;
        for (int i = 0; i < nd; i++) begin
            b[1+i] = d[i];
            if (d[i]) ones++;
        end
        n = 1 + nd;
        if (c[3]) begin
            if (c[5]) p = ~c[4];
            else p = c[4] ? (ones % 2 == 1) : (ones % 2 == 0);
            b[n] = p;
            n++;
        end
        n += c[2] ? 2 : 1;
        return n;
    endfunction

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_byte(input logic [7:0] b);
        @(negedge clk);
        wr_en = 1; wr_data = b;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic wait_empty();
        int k = 0;
        while (!tx_empty && k < 20000) begin @(negedge clk); k++; end
    endtask

    task automatic recv(input int n, input int div, output logic [11:0] got);
        int t = 16 * div;
        int k = 0;
        got = 12'hFFF;
        while (txd !== 1'b0 && k < 30000) begin @(negedge clk); k++; end
        cycles(t/2 - 1);
        for (int j = 0; j < n; j++) begin
            got[j] = txd;
            if (j != n-1) cycles(t);
        end
    endtask

    task automatic send_check(input logic [7:0] d, input logic [6:0] c, input int div, input string req);
        logic [11:0] e, g;
        int n;
        wait_empty();
        @(negedge clk);
        line_ctl = c; divisor = div[15:0];
        n = exp_frame(d, c, e);
        write_byte(d);
        recv(n, div, g);
        check(g == e, req, int'(g), int'(e));
    endtask

    initial begin
        logic [11:0] e, g;
        int n, cnt;
        void'($urandom(32'h5eed_1234));
        cycles(3);
        check(txd === 1'b1, "R1 txd", int'(txd), 1);
        check(thr_empty === 1'b1, "R1 thr_empty", int'(thr_empty), 1);
        check(tx_empty === 1'b1, "R1 tx_empty", int'(tx_empty), 1);
        @(negedge clk); rst = 0;
        cycles(2);
        check(txd === 1'b1 && tx_empty === 1'b1, "R1 after release", int'({txd, tx_empty}), 3);

        // R2: start bit length for 0x01 at divisor 5
        @(negedge clk); divisor = 16'd5; line_ctl = 7'h03;
        write_byte(8'h01);
        while (txd !== 1'b0) @(negedge clk);
        // R5 mid-frame status
        check(thr_empty === 1'b1 && tx_empty === 1'b0, "R5 mid-frame", int'({thr_empty, tx_empty}), 2);
        cnt = 0;
        while (txd === 1'b0) begin cnt++; @(negedge clk); end
        check(cnt == 80, "R2 bit time", cnt, 80);
        wait_empty();
        check(tx_empty === 1'b1 && txd === 1'b1, "R5 idle after frame", int'({tx_empty, txd}), 3);

        // R3 / R4 directed formats
        send_check(8'hA5, 7'h03, 2, "R3 8N1");
        send_check(8'h1B, 7'h04, 1, "R3 5 bits two stop");
        send_check(8'h07, 7'h1B, 1, "R4 even parity");
        send_check(8'h07, 7'h0B, 1, "R4 odd parity");
        send_check(8'h07, 7'h3B, 1, "R4 stick zero");
        send_check(8'h06, 7'h2A, 1, "R4 stick one 7 bits");

        // random frames: R3 R4 R2
        for (int i = 0; i < 20; i++) begin
            logic [7:0] d;
            logic [6:0] c;
            int dv;
            d = 8'($urandom);
            c = 7'($urandom) & 7'h3F;
            dv = 1 + int'($urandom % 3);
            send_check(d, c, dv, "R3 R4 random frame");
        end

        // R11 + R6: zero divisor, fill queue, one extra write dropped
        wait_empty();
        @(negedge clk); divisor = 16'd0; line_ctl = 7'h03;
        for (int i = 0; i < 17; i++) write_byte(8'(8'h30 + i));
        cycles(500);
        check(txd === 1'b1, "R11 line high", int'(txd), 1);
        check(thr_empty === 1'b0 && tx_empty === 1'b0, "R11 data kept", int'({thr_empty, tx_empty}), 0);
        @(negedge clk); divisor = 16'd1;
        for (int i = 0; i < 16; i++) begin
            n = exp_frame(8'(8'h30 + i), 7'h03, e);
            recv(n, 1, g);
            check(g == e, "R6 order", int'(g), int'(e));
        end
        cycles(400);
        check(txd === 1'b1 && tx_empty === 1'b1, "R6 full write dropped", int'({txd, tx_empty}), 3);

        // R8 R9: one-cycle break pulse inside a character
        wait_empty();
        @(negedge clk); divisor = 16'd2; line_ctl = 7'h03;
        write_byte(8'h41); write_byte(8'h42); write_byte(8'h43);
        n = exp_frame(8'h41, 7'h03, e);
        recv(n, 2, g);
        check(g == e, "R8 char before break", int'(g), int'(e));
        while (txd !== 1'b0) @(negedge clk);
        cycles(96);
        line_ctl = 7'h43;
        @(negedge clk);
        line_ctl = 7'h03;
        check(txd === 1'b0, "R7 break low next cycle", int'(txd), 0);
        cnt = 0;
        while (txd === 1'b0 && cnt < 5000) begin cnt++; @(negedge clk); end
        check(cnt >= 352 && cnt <= 384, "R9 hold window", cnt, 352);
        n = exp_frame(8'h43, 7'h03, e);
        recv(n, 2, g);
        check(g == e, "R8 aborted char skipped", int'(g), int'(e));
        wait_empty();
        cycles(200);
        check(txd === 1'b1 && tx_empty === 1'b1, "R8 no resend", int'({txd, tx_empty}), 3);

        // R7 R10: long break while idle, byte queued during it
        @(negedge clk); line_ctl = 7'h43;
        @(negedge clk);
        check(txd === 1'b0, "R7 idle break low", int'(txd), 0);
        cycles(100);
        write_byte(8'h5A);
        cycles(600);
        check(txd === 1'b0, "R9 held while requested", int'(txd), 0);
        check(thr_empty === 1'b0, "R10 byte queued", int'(thr_empty), 0);
        @(negedge clk); line_ctl = 7'h03;
        while (txd === 1'b0) @(negedge clk);
        n = exp_frame(8'h5A, 7'h03, e);
        recv(n, 2, g);
        check(g == e, "R10 sent after break", int'(g), int'(e));

        wait_empty();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL R1 watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule